// File: doc/BRIEF.md
# Cipher Engine Control and Status Registers

This unit is the software-facing register unit that sits in front of a block-cipher datapath. A simple synchronous bus port reads and writes a control word and a status word. The control word holds the engine enable, the two-bit operating mode and the three-bit chaining mode. It also holds the interrupt unmask bits and the DMA request enables. The unit passes the enable and the two mode fields straight to the cipher core.

The core reports three kinds of event with one-cycle pulses: computation done, read error and write error. The unit turns each pulse into a sticky status flag that software clears by writing a one to a clear strobe in the control word. From the flags and the unmask bits it builds a single interrupt line.

Two phase indicators from the core gate the input-side and output-side DMA request lines. The requests are allowed only in the plain encrypt and decrypt modes. While the engine is running, the chaining-mode field is protected against writes, so the chaining scheme cannot change in the middle of a message.

Top module: `cipher_ctl_regs`

## Requirements
- R1: After a synchronous reset, every control field and status flag is 0. The interrupt and both DMA requests are 0, the core settings are 0 and the read data is 0.
- R2: The control word is at byte address 0. Its bit positions are: enable at bit 0, operating mode at bits 4:3, chaining mode low bits at 6:5, done-clear strobe at 7, error-clear strobe at 8, done unmask at 9, error unmask at 10, input DMA enable at 11, output DMA enable at 12 and chaining mode high bit at 16. A read returns the stored fields one cycle after the read strobe. Bits 7 and 8 and all unlisted bits read as 0. A read of any address other than 0 or 4 returns 0.
- R3: The status word is at byte address 4, with done at bit 0, read error at bit 1 and write error at bit 2. Each event pulse sets its flag, and the flag is visible from the clock edge that samples the pulse. A write to address 4 changes nothing.
- R4: Writing the control word with bit 7 at 1 clears the done flag. Writing it with bit 7 at 0 leaves the done flag unchanged.
- R5: Writing the control word with bit 8 at 1 clears both error flags. Writing it with bit 8 at 0 leaves them unchanged.
- R6: When an event pulse and the clear write for the same flag arrive in the same cycle, the flag ends up set.
- R7: The interrupt line is (done AND done-unmask) OR ((read error OR write error) AND error-unmask). It is registered, so it follows the flag and unmask state one cycle later.
- R8: The input DMA request is high only in cycles after the input phase indicator was high and the input DMA enable was set. The output DMA request follows the same rule with the output phase indicator and the output DMA enable. Each request is registered, one cycle after its inputs.
- R9: The operating mode encodes 00 as encrypt, 01 as key derivation, 10 as decrypt and 11 as derive-then-decrypt. DMA requests stay low in modes 01 and 11, whatever the enables and phases are.
- R10: A control write leaves the chaining mode unchanged if the enable bit was 1 before the write and the written enable bit is also 1. Every other control write loads the chaining mode. The chaining mode encodes 000 ECB, 001 CBC, 010 CTR, 011 GCM/GMAC and 100 CCM.
- R11: The core outputs carry the stored enable, operating mode and chaining mode from the clock edge that accepts the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data, held between reads |
| ev_done | input | 1 | Computation-done pulse from the core |
| ev_rderr | input | 1 | Read-error pulse from the core |
| ev_wrerr | input | 1 | Write-error pulse from the core |
| phase_in | input | 1 | Core is in its input data phase |
| phase_out | input | 1 | Core is in its output data phase |
| irq | output | 1 | Masked interrupt |
| dma_in_req | output | 1 | Input-side DMA request |
| dma_out_req | output | 1 | Output-side DMA request |
| core_en | output | 1 | Engine enable to the core |
| core_mode | output | 2 | Operating mode to the core |
| core_chain | output | 3 | Chaining mode to the core |

## Verification
A wrong flag or control bit appears at the ports within one or two cycles. A bad flag shows on the interrupt one cycle after the edge that stored it, and on a status read one cycle after the read strobe. A lost chaining-mode lock or a bad mode gate appears on core_chain or a DMA request line right after the offending write. The bench runs a behavioural reference model and compares it with every output on every clock. Because of that, a divergence is reported in the first cycle it becomes visible, not at the end of a directed sequence. Directed sequences aim at the same-cycle set/clear race, the lock with and without a clearing enable, and each mode's DMA gate.

// File: rtl/cipher_ctl_pkg.sv
package cipher_ctl_pkg;

  typedef enum logic [1:0] {
    OPM_ENCRYPT        = 2'b00,
    OPM_KEY_DERIVE     = 2'b01,
    OPM_DECRYPT        = 2'b10,
    OPM_DERIVE_DECRYPT = 2'b11
  } opmode_e;

  typedef struct packed {
    logic       dma_out_en;
    logic       dma_in_en;
    logic       err_ie;
    logic       done_ie;
    logic [2:0] chain;
    opmode_e    mode;
    logic       en;
  } ctl_t;

  localparam int EN_BIT       = 0;
  localparam int MODE_LO      = 3;
  localparam int CHAIN_LO     = 5;
  localparam int CLR_DONE_BIT = 7;
  localparam int CLR_ERR_BIT  = 8;
  localparam int DONE_IE_BIT  = 9;
  localparam int ERR_IE_BIT   = 10;
  localparam int DIN_BIT      = 11;
  localparam int DOUT_BIT     = 12;
  localparam int CHAIN_HI_BIT = 16;

  localparam int N_FLAGS  = 3;
  localparam int F_DONE   = 0;
  localparam int F_RDERR  = 1;
  localparam int F_WRERR  = 2;

  function automatic logic [31:0] ctl_word(input ctl_t c);
    logic [31:0] w;
    w = '0;
    w[EN_BIT]               = c.en;
    w[MODE_LO+1:MODE_LO]    = c.mode;
    w[CHAIN_LO+1:CHAIN_LO]  = c.chain[1:0];
    w[CHAIN_HI_BIT]         = c.chain[2];
    w[DONE_IE_BIT]          = c.done_ie;
    w[ERR_IE_BIT]           = c.err_ie;
    w[DIN_BIT]              = c.dma_in_en;
    w[DOUT_BIT]             = c.dma_out_en;
    return w;
  endfunction

  function automatic logic dma_mode_ok(input opmode_e m);
    return (m == OPM_ENCRYPT) || (m == OPM_DECRYPT);
  endfunction

endpackage

// File: rtl/ctl_reg_file.sv
module ctl_reg_file
  import cipher_ctl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctl,
  input  logic [DATA_W-1:0] wdata,
  output ctl_t              ctl,
  output logic              clr_done,
  output logic              clr_err
);

  logic chain_locked;
  logic unused_wbits;

  assign chain_locked = ctl.en && wdata[EN_BIT];
  assign clr_done     = wr_ctl && wdata[CLR_DONE_BIT];
  assign clr_err      = wr_ctl && wdata[CLR_ERR_BIT];
  assign unused_wbits = ^{wdata[DATA_W-1:CHAIN_HI_BIT+1], wdata[CHAIN_HI_BIT-1:DOUT_BIT+1],
                          wdata[MODE_LO-1:EN_BIT+1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl <= '0;
    end else if (wr_ctl) begin
      ctl.en         <= wdata[EN_BIT];
      ctl.mode       <= opmode_e'(wdata[MODE_LO+1:MODE_LO]);
      ctl.done_ie    <= wdata[DONE_IE_BIT];
      ctl.err_ie     <= wdata[ERR_IE_BIT];
      ctl.dma_in_en  <= wdata[DIN_BIT];
      ctl.dma_out_en <= wdata[DOUT_BIT];
      if (!chain_locked)
        ctl.chain <= {wdata[CHAIN_HI_BIT], wdata[CHAIN_LO+1:CHAIN_LO]};
    end
  end

  // R10
  chain_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ctl && ctl.en && wdata[EN_BIT]) |=> $stable(ctl.chain));

  // R11
  en_load_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ctl |=> (ctl.en == $past(wdata[EN_BIT])));

endmodule

// File: rtl/ctl_status_flags.sv
module ctl_status_flags
  import cipher_ctl_pkg::*;
#(
  parameter int NF = N_FLAGS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] set_ev,
  input  logic [NF-1:0] clr,
  output logic [NF-1:0] flags
);

  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)
        flags[i] <= 1'b0;
      else
        flags[i] <= set_ev[i] | (flags[i] & ~clr[i]);
    end

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      set_ev[i] |=> flags[i]);

    // R4 R5
    clear_chk: assert property (@(posedge clk) disable iff (rst)
      (clr[i] && !set_ev[i]) |=> !flags[i]);
  end

endmodule

// File: rtl/ctl_req_gen.sv
module ctl_req_gen
  import cipher_ctl_pkg::*;
#(
  parameter int NF = N_FLAGS
) (
  input  logic          clk,
  input  logic          rst,
  input  ctl_t          ctl,
  input  logic [NF-1:0] flags,
  input  logic          phase_in,
  input  logic          phase_out,
  output logic          irq,
  output logic          dma_in_req,
  output logic          dma_out_req
);

  logic done_hit, err_hit, mode_ok;

  assign done_hit = flags[F_DONE] && ctl.done_ie;
  assign err_hit  = (flags[F_RDERR] || flags[F_WRERR]) && ctl.err_ie;
  assign mode_ok  = dma_mode_ok(ctl.mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq         <= 1'b0;
      dma_in_req  <= 1'b0;
      dma_out_req <= 1'b0;
    end else begin
      irq         <= done_hit || err_hit;
      dma_in_req  <= phase_in  && ctl.dma_in_en  && mode_ok;
      dma_out_req <= phase_out && ctl.dma_out_en && mode_ok;
    end
  end

  // R7
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|flags));

  // R9
  dma_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (dma_in_req || dma_out_req) |->
      ($past(ctl.mode) == OPM_ENCRYPT || $past(ctl.mode) == OPM_DECRYPT));

  // R8
  dma_in_phase_chk: assert property (@(posedge clk) disable iff (rst)
    dma_in_req |-> $past(phase_in));

endmodule

// File: rtl/cipher_ctl_regs.sv
module cipher_ctl_regs
  import cipher_ctl_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int CTL_ADDR  = 0,
  parameter int STAT_ADDR = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ev_done,
  input  logic              ev_rderr,
  input  logic              ev_wrerr,
  input  logic              phase_in,
  input  logic              phase_out,
  output logic              irq,
  output logic              dma_in_req,
  output logic              dma_out_req,
  output logic              core_en,
  output logic [1:0]        core_mode,
  output logic [2:0]        core_chain
);

  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(CTL_ADDR);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

  ctl_t               ctl;
  logic               clr_done, clr_err;
  logic [N_FLAGS-1:0] flags, set_ev, clr_vec;
  logic               hit_ctl, hit_stat;
  logic [DATA_W-1:0]  rd_mux;

  assign hit_ctl  = (bus_addr == A_CTL);
  assign hit_stat = (bus_addr == A_STAT);
  assign set_ev   = {ev_wrerr, ev_rderr, ev_done};
  assign clr_vec  = {clr_err, clr_err, clr_done};

  ctl_reg_file #(.DATA_W(DATA_W)) i_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_ctl   (bus_wr && hit_ctl),
    .wdata    (bus_wdata),
    .ctl      (ctl),
    .clr_done (clr_done),
    .clr_err  (clr_err)
  );

  ctl_status_flags #(.NF(N_FLAGS)) i_flags (
    .clk    (clk),
    .rst    (rst),
    .set_ev (set_ev),
    .clr    (clr_vec),
    .flags  (flags)
  );

  ctl_req_gen #(.NF(N_FLAGS)) i_reqs (
    .clk         (clk),
    .rst         (rst),
    .ctl         (ctl),
    .flags       (flags),
    .phase_in    (phase_in),
    .phase_out   (phase_out),
    .irq         (irq),
    .dma_in_req  (dma_in_req),
    .dma_out_req (dma_out_req)
  );

  always_comb begin
    rd_mux = '0;
    if (hit_ctl)
      rd_mux = DATA_W'(ctl_word(ctl));
    else if (hit_stat)
      rd_mux[N_FLAGS-1:0] = flags;
  end

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (bus_rd)
      bus_rdata <= rd_mux;
  end

  assign core_en    = ctl.en;
  assign core_mode  = ctl.mode;
  assign core_chain = ctl.chain;

  // R3
  stat_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && hit_stat && !(|set_ev)) |=> $stable(flags));

endmodule

// File: tb/test_cipher_ctl_regs.sv
`timescale 1ns/1ps
module test_cipher_ctl_regs;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 0, bus_rd = 0;
  logic [3:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        ev_done = 0, ev_rderr = 0, ev_wrerr = 0;
  logic        phase_in = 0, phase_out = 0;
  logic        irq, dma_in_req, dma_out_req, core_en;
  logic [1:0]  core_mode;
  logic [2:0]  core_chain;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  cipher_ctl_regs i_cipher_ctl_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_done(ev_done),
    .ev_rderr(ev_rderr), .ev_wrerr(ev_wrerr), .phase_in(phase_in),
    .phase_out(phase_out), .irq(irq), .dma_in_req(dma_in_req),
    .dma_out_req(dma_out_req), .core_en(core_en), .core_mode(core_mode),
    .core_chain(core_chain)
  );

  // behavioural reference model
  int m_en, m_mode, m_chain, m_die, m_eie, m_din_en, m_dout_en;
  int m_done, m_re, m_we, m_irq, m_din, m_dout;
  logic [31:0] m_rdata;

  function automatic logic [31:0] m_ctl_word();
    return (m_en) | (m_mode << 3) | ((m_chain & 3) << 5) | ((m_chain >> 2) << 16) |
           (m_die << 9) | (m_eie << 10) | (m_din_en << 11) | (m_dout_en << 12);
  endfunction

  always @(posedge clk) begin
    bit dmaok, wc;
    if (rst) begin
      m_en = 0; m_mode = 0; m_chain = 0; m_die = 0; m_eie = 0; m_din_en = 0;
      m_dout_en = 0; m_done = 0; m_re = 0; m_we = 0; m_irq = 0; m_din = 0;
      m_dout = 0; m_rdata = 0;
    end else begin
      if (bus_rd)
        m_rdata = (bus_addr == 0) ? m_ctl_word() :
                  (bus_addr == 4) ? 32'(m_done | (m_re << 1) | (m_we << 2)) : 32'h0;
      m_irq  = (m_done && m_die) || ((m_re || m_we) && m_eie);
      dmaok  = (m_mode == 0) || (m_mode == 2);
      m_din  = phase_in && m_din_en && dmaok;
      m_dout = phase_out && m_dout_en && dmaok;
      wc = bus_wr && (bus_addr == 0);
      m_done = ev_done  || (m_done && !(wc && bus_wdata[7]));
      m_re   = ev_rderr || (m_re && !(wc && bus_wdata[8]));
      m_we   = ev_wrerr || (m_we && !(wc && bus_wdata[8]));
      if (wc) begin
        if (!(m_en && bus_wdata[0]))
          m_chain = {bus_wdata[16], bus_wdata[6:5]};
        m_en = bus_wdata[0]; m_mode = bus_wdata[4:3]; m_die = bus_wdata[9];
        m_eie = bus_wdata[10]; m_din_en = bus_wdata[11]; m_dout_en = bus_wdata[12];
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // per-clock comparison against the model
  always @(posedge clk) begin
    #1;
    if (!rst && !finished) begin
      check("R7 irq", 32'(irq), 32'(m_irq));
      check("R8 dma_in_req", 32'(dma_in_req), 32'(m_din));
      check("R8 dma_out_req", 32'(dma_out_req), 32'(m_dout));
      check("R11 core_en", 32'(core_en), 32'(m_en));
      check("R11 core_mode", 32'(core_mode), 32'(m_mode));
      check("R10 core_chain", 32'(core_chain), 32'(m_chain));
      check("R2 bus_rdata", bus_rdata, m_rdata);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd_expect(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0;
    check(tag, bus_rdata, exp);
  endtask

  task automatic pulse(input logic d, input logic r, input logic w);
    @(negedge clk); ev_done = d; ev_rderr = r; ev_wrerr = w;
    @(negedge clk); ev_done = 0; ev_rderr = 0; ev_wrerr = 0;
  endtask

  localparam logic [31:0] BASE = 32'h0000_1E20;

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    check("R1 irq", 32'(irq), 0);
    check("R1 dma", 32'({dma_in_req, dma_out_req}), 0);
    check("R1 core", 32'({core_en, core_mode, core_chain}), 0);
    check("R1 rdata", bus_rdata, 0);
    rd_expect(0, 0, "R1 ctl word");
    rd_expect(4, 0, "R1 status word");

    // R2: strobes and reserved bits read 0
    wr(0, BASE | 32'h0010_0180);
    rd_expect(0, BASE, "R2 ctl readback");
    rd_expect(8, 0, "R2 unmapped read");
    check("R11 core_chain CBC", 32'(core_chain), 1);

    // R8
    @(negedge clk); phase_in = 1;
    @(negedge clk); check("R8 in request", 32'(dma_in_req), 1);
    check("R8 out idle", 32'(dma_out_req), 0);
    phase_in = 0; phase_out = 1;
    @(negedge clk); check("R8 out request", 32'(dma_out_req), 1);
    check("R8 in idle", 32'(dma_in_req), 0);
    phase_in = 1;
    // R9
    wr(0, BASE | 32'h08);
    @(negedge clk); check("R9 key derive blocks dma", 32'({dma_in_req, dma_out_req}), 0);
    wr(0, BASE | 32'h18);
    @(negedge clk); check("R9 mode 11 blocks dma", 32'({dma_in_req, dma_out_req}), 0);
    wr(0, BASE | 32'h10);
    @(negedge clk); check("R9 decrypt allows dma", 32'({dma_in_req, dma_out_req}), 3);
    phase_in = 0; phase_out = 0;
    wr(0, BASE);

    // R3, R7
    pulse(1, 0, 0);
    rd_expect(4, 1, "R3 done flag");
    check("R7 irq on done", 32'(irq), 1);
    wr(4, 0);
    rd_expect(4, 1, "R3 status write ignored");
    // R4
    wr(0, BASE);
    rd_expect(4, 1, "R4 zero strobe keeps done");
    wr(0, BASE | 32'h80);
    rd_expect(4, 0, "R4 done cleared");
    check("R7 irq drops", 32'(irq), 0);

    // R5
    pulse(0, 1, 1);
    rd_expect(4, 6, "R3 error flags");
    wr(0, BASE & ~32'h400);
    @(negedge clk); check("R7 masked error irq", 32'(irq), 0);
    wr(0, BASE | 32'h80);
    rd_expect(4, 6, "R5 done strobe leaves errors");
    wr(0, BASE | 32'h100);
    rd_expect(4, 0, "R5 errors cleared");

    // R6
    @(negedge clk); ev_done = 1; bus_wr = 1; bus_addr = 0; bus_wdata = BASE | 32'h80;
    @(negedge clk); ev_done = 0; bus_wr = 0;
    rd_expect(4, 1, "R6 set wins over clear");
    wr(0, BASE | 32'h80);

    // R10
    wr(0, 32'h0000_1E41);
    check("R10 load while disabled", 32'(core_chain), 2);
    wr(0, 32'h0001_1E01);
    check("R10 locked while enabled", 32'(core_chain), 2);
    rd_expect(0, 32'h0000_1E41, "R10 locked readback");
    wr(0, 32'h0001_1E00);
    check("R10 load with enable clear", 32'(core_chain), 4);
    check("R11 core_en off", 32'(core_en), 0);

    // mixed stimulus, compared against the model every clock
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      ev_done   = ($urandom % 8) == 0;
      ev_rderr  = ($urandom % 12) == 0;
      ev_wrerr  = ($urandom % 12) == 0;
      phase_in  = $urandom % 2;
      phase_out = $urandom % 2;
      bus_wr    = ($urandom % 4) == 0;
      bus_rd    = ($urandom % 3) == 0;
      bus_addr  = 4'(($urandom % 3) * 4);
      bus_wdata = $urandom & 32'h0001_1FF9;
    end
    @(negedge clk);
    ev_done = 0; ev_rderr = 0; ev_wrerr = 0; bus_wr = 0; bus_rd = 0;
    repeat (3) @(negedge clk);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule